// File: doc/BRIEF.md
# Selectable 8/16-bit parallel data width adapter

The adapter sits between an internal byte-wide serializer path and an external parallel link bus. That bus runs either one byte per transfer or two bytes per transfer. In wide mode, received bytes are packed in pairs into words and transmit words are split back into bytes. A single high-byte-valid line marks whether the upper byte of a word carries data. Because this line flips direction with the transmit-valid handshake, it can mark an odd final byte in both directions.

The bus arrangement is captured once, on the first clock edge after reset is released, and stays fixed until the next reset. A third arrangement keeps the narrow width but splits the bus into two one-way lanes. In that arrangement the lower lane carries receive bytes and the upper lane carries transmit bytes. Pad drivers and clock generation are outside the block, so every bidirectional bus signal is presented as a separate input, output and output-enable.

Top module: `utmi_width_adapter`

## Requirements
- R1: `wide_sel_i` and `uni_sel_i` are sampled at the first rising clock edge after `rst_ni` goes high. Arrangement priority is: wide if `wide_sel_i`=1, else unidirectional narrow if `uni_sel_i`=1, else bidirectional narrow. Later changes on either input have no effect until the next reset.
- R2: Bidirectional narrow receive: each byte offered with `ser_rx_vld_i` appears on `bus_rx_o[7:0]` with `rx_valid_o`=1 in the following cycle. `bus_rx_o[15:8]`=0 and `hbv_o`=0.
- R3: Wide receive: the first byte of a pair is held, and the second produces a word in the next cycle. That word has the first byte in bits 7:0, the second byte in bits 15:8, and `rx_valid_o`=`hbv_o`=1.
- R4: Wide receive: if `ser_rx_end_i` arrives while one byte is held, the next cycle gives a word with that byte in bits 7:0, bits 15:8=0, `rx_valid_o`=1 and `hbv_o`=0. An end pulse with no byte held produces no word.
- R5: `hbv_oe_o` is 1 exactly when the wide arrangement is latched and `tx_valid_i`=0. In the narrow arrangements `hbv_oe_o` and `hbv_o` stay 0.
- R6: Transmit acceptance: a word is taken at a clock edge where `tx_valid_i`=`tx_ready_o`=1. `tx_ready_o` is 1 when no byte is pending, or when one byte is pending and `ser_tx_rdy_i`=1. In bidirectional narrow mode, the byte sent is `bus_tx_i[7:0]`.
- R7: Wide transmit: an accepted word with `hbv_i`=1 yields two bytes, bits 7:0 first and then bits 15:8. With `hbv_i`=0 it yields only bits 7:0.
- R8: Unidirectional narrow mode: receive bytes appear on `bus_rx_o[7:0]` as in R2, and transmit bytes are taken from `bus_tx_i[15:8]`.
- R9: `ser_tx_vld_o` is 1 while a byte is pending, and `ser_tx_byte_o` holds steady until `ser_tx_rdy_i`=1 at a clock edge.
- R10: While reset is applied: `rx_valid_o`=0, `hbv_o`=0, `hbv_oe_o`=0, `ser_tx_vld_o`=0 and `tx_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wide_sel_i | input | 1 | 1 selects two-byte bus, sampled after reset |
| uni_sel_i | input | 1 | 1 selects split one-way lanes in narrow mode |
| bus_rx_o | output | 2*BYTE_W | Receive data toward the link |
| rx_valid_o | output | 1 | Receive word/byte valid |
| hbv_o | output | 1 | Upper receive byte valid |
| hbv_oe_o | output | 1 | Drive enable for the high-byte-valid pad |
| hbv_i | input | 1 | Upper transmit byte valid |
| bus_tx_i | input | 2*BYTE_W | Transmit data from the link |
| tx_valid_i | input | 1 | Transmit data valid |
| tx_ready_o | output | 1 | Transmit word accepted at this edge |
| ser_rx_byte_i | input | BYTE_W | Byte from the deserializer |
| ser_rx_vld_i | input | 1 | Deserializer byte strobe |
| ser_rx_end_i | input | 1 | Receive packet end pulse |
| ser_tx_byte_o | output | BYTE_W | Byte to the serializer |
| ser_tx_vld_o | output | 1 | Serializer byte pending |
| ser_tx_rdy_i | input | 1 | Serializer takes the byte at this edge |

## Verification
The bench builds the block with its default byte width of 8. It then resets it three times, once for each latched arrangement. This covers the wide packing paths, including odd packet ends, as well as both narrow lane layouts and the width latch ignoring later select changes. Serializer back-pressure is run both continuous and throttled. This exercises the ready rule at its one-pending-byte corner and the hold of an unaccepted byte.

// File: rtl/utmi_width_pkg.sv
package utmi_width_pkg;
  typedef enum logic [1:0] {
    BUS_NARROW_BI  = 2'd0,
    BUS_NARROW_UNI = 2'd1,
    BUS_WIDE       = 2'd2
  } bus_mode_e;
endpackage

// File: rtl/utmi_width_mode_latch.sv
module utmi_width_mode_latch
  import utmi_width_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wide_sel_i,
  input  logic      uni_sel_i,
  output bus_mode_e mode_o,
  output logic      done_o
);
  bus_mode_e mode_q;
  logic      done_q;

  // capture once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= BUS_NARROW_BI;
      done_q <= 1'b0;
    end else if (!done_q) begin
      done_q <= 1'b1;
      if (wide_sel_i)     mode_q <= BUS_WIDE;
      else if (uni_sel_i) mode_q <= BUS_NARROW_UNI;
      else                mode_q <= BUS_NARROW_BI;
    end
  end

  assign mode_o = mode_q;
  assign done_o = done_q;
endmodule

// File: rtl/utmi_width_rx_pack.sv
module utmi_width_rx_pack #(
  parameter int BYTE_W = 8,
  localparam int BUS_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              end_i,
  output logic [BUS_W-1:0]  word_o,
  output logic              vld_o,
  output logic              hi_o
);
  logic [BYTE_W-1:0] held_q;
  logic              pend_q;
  logic [BUS_W-1:0]  word_q;
  logic              vld_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      pend_q <= 1'b0;
      word_q <= '0;
      vld_q  <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      hi_q  <= 1'b0;
      if (byte_vld_i) begin
        if (!wide_i) begin
          word_q <= {{BYTE_W{1'b0}}, byte_i};
          vld_q  <= 1'b1;
        end else if (pend_q) begin
          word_q <= {byte_i, held_q};
          vld_q  <= 1'b1;
          hi_q   <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          held_q <= byte_i;
          pend_q <= 1'b1;
        end
      end else if (end_i && pend_q) begin
        // odd packet: flush lone low byte
        word_q <= {{BYTE_W{1'b0}}, held_q};
        vld_q  <= 1'b1;
        pend_q <= 1'b0;
      end
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;
  assign hi_o   = hi_q;
endmodule

// File: rtl/utmi_width_tx_unpack.sv
module utmi_width_tx_unpack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              hi_vld_i,
  input  logic              word_vld_i,
  output logic              ready_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  input  logic              byte_rdy_i
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [1:0]        cnt_q;
  logic              sel_q;
  logic              take, pop;

  assign byte_vld_o = (cnt_q != 2'd0);
  assign ready_o    = (cnt_q == 2'd0) || ((cnt_q == 2'd1) && byte_rdy_i);
  assign take       = word_vld_i && ready_o;
  assign pop        = byte_vld_o && byte_rdy_i;
  assign byte_o     = sel_q ? hi_q : lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cnt_q <= 2'd0;
      sel_q <= 1'b0;
    end else if (take) begin
      lo_q  <= lo_i;
      hi_q  <= hi_i;
      cnt_q <= (wide_i && hi_vld_i) ? 2'd2 : 2'd1;
      sel_q <= 1'b0;
    end else if (pop) begin
      cnt_q <= cnt_q - 2'd1;
      sel_q <= 1'b1;
    end
  end
endmodule

// File: rtl/utmi_width_adapter.sv
module utmi_width_adapter
  import utmi_width_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int BUS_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_sel_i,
  input  logic              uni_sel_i,
  output logic [BUS_W-1:0]  bus_rx_o,
  output logic              rx_valid_o,
  output logic              hbv_o,
  output logic              hbv_oe_o,
  input  logic              hbv_i,
  input  logic [BUS_W-1:0]  bus_tx_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [BYTE_W-1:0] ser_rx_byte_i,
  input  logic              ser_rx_vld_i,
  input  logic              ser_rx_end_i,
  output logic [BYTE_W-1:0] ser_tx_byte_o,
  output logic              ser_tx_vld_o,
  input  logic              ser_tx_rdy_i
);
  bus_mode_e         cfg_mode;
  logic              cfg_done;
  logic              wide, uni;
  logic              rx_hi;
  logic [BYTE_W-1:0] tx_lo;

  utmi_width_mode_latch u_mode (
    .clk_i, .rst_ni, .wide_sel_i, .uni_sel_i,
    .mode_o (cfg_mode),
    .done_o (cfg_done)
  );

  assign wide = (cfg_mode == BUS_WIDE);
  assign uni  = (cfg_mode == BUS_NARROW_UNI);

  utmi_width_rx_pack #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i, .rst_ni,
    .wide_i     (wide),
    .byte_i     (ser_rx_byte_i),
    .byte_vld_i (ser_rx_vld_i),
    .end_i      (ser_rx_end_i),
    .word_o     (bus_rx_o),
    .vld_o      (rx_valid_o),
    .hi_o       (rx_hi)
  );

  // one-way layout: transmit lane is the upper half
  assign tx_lo = uni ? bus_tx_i[BUS_W-1:BYTE_W] : bus_tx_i[BYTE_W-1:0];

  utmi_width_tx_unpack #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i, .rst_ni,
    .wide_i     (wide),
    .lo_i       (tx_lo),
    .hi_i       (bus_tx_i[BUS_W-1:BYTE_W]),
    .hi_vld_i   (hbv_i),
    .word_vld_i (tx_valid_i),
    .ready_o    (tx_ready_o),
    .byte_o     (ser_tx_byte_o),
    .byte_vld_o (ser_tx_vld_o),
    .byte_rdy_i (ser_tx_rdy_i)
  );

  assign hbv_o    = wide && rx_hi;
  assign hbv_oe_o = wide && !tx_valid_i;
endmodule

// File: rtl/utmi_width_adapter_chk.sv
module utmi_width_adapter_chk
  import utmi_width_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int BUS_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input bus_mode_e         cfg_mode,
  input logic              cfg_done,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic              hbv_o,
  input logic              hbv_oe_o,
  input logic              rx_valid_o,
  input logic [BUS_W-1:0]  bus_rx_o,
  input logic [BYTE_W-1:0] ser_tx_byte_o,
  input logic              ser_tx_vld_o,
  input logic              ser_tx_rdy_i
);
  assert_mode_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done |=> cfg_done && $stable(cfg_mode));

  assert_narrow_upper_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && cfg_mode != BUS_WIDE) |-> (bus_rx_o[BUS_W-1:BYTE_W] == '0));

  assert_hbv_needs_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hbv_o |-> rx_valid_o);

  assert_odd_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !hbv_o) |-> (bus_rx_o[BUS_W-1:BYTE_W] == '0));

  assert_hbv_turn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |-> !hbv_oe_o);

  assert_hbv_narrow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode != BUS_WIDE) |-> (!hbv_oe_o && !hbv_o));

  assert_ready_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_tx_vld_o |-> tx_ready_o);

  assert_accept_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> ser_tx_vld_o);

  assert_byte_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_tx_vld_o && !ser_tx_rdy_i) |=> (ser_tx_vld_o && $stable(ser_tx_byte_o)));
endmodule

bind utmi_width_adapter utmi_width_adapter_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_mode      (cfg_mode),
  .cfg_done      (cfg_done),
  .tx_valid_i    (tx_valid_i),
  .tx_ready_o    (tx_ready_o),
  .hbv_o         (hbv_o),
  .hbv_oe_o      (hbv_oe_o),
  .rx_valid_o    (rx_valid_o),
  .bus_rx_o      (bus_rx_o),
  .ser_tx_byte_o (ser_tx_byte_o),
  .ser_tx_vld_o  (ser_tx_vld_o),
  .ser_tx_rdy_i  (ser_tx_rdy_i)
);

// File: tb/utmi_width_adapter_tb_top.sv
`timescale 1ns/1ps
module utmi_width_adapter_tb_top;
  localparam int BW = 8;
  localparam int WW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0, wide_sel = 1'b0, uni_sel = 1'b0;
  logic [WW-1:0] bus_rx;
  logic          rx_valid, hbv_out, hbv_oe, hbv_in = 1'b0;
  logic [WW-1:0] bus_tx = '0;
  logic          tx_valid = 1'b0, tx_ready;
  logic [BW-1:0] s_rx_byte = '0;
  logic          s_rx_vld = 1'b0, s_rx_end = 1'b0;
  logic [BW-1:0] s_tx_byte;
  logic          s_tx_vld, s_tx_rdy = 1'b1;

  utmi_width_adapter #(.BYTE_W(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wide_sel_i(wide_sel), .uni_sel_i(uni_sel),
    .bus_rx_o(bus_rx), .rx_valid_o(rx_valid), .hbv_o(hbv_out), .hbv_oe_o(hbv_oe),
    .hbv_i(hbv_in), .bus_tx_i(bus_tx), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .ser_rx_byte_i(s_rx_byte), .ser_rx_vld_i(s_rx_vld), .ser_rx_end_i(s_rx_end),
    .ser_tx_byte_o(s_tx_byte), .ser_tx_vld_o(s_tx_vld), .ser_tx_rdy_i(s_tx_rdy)
  );

  int    checks = 0, errors = 0, cyc = 0;
  bit    finished = 1'b0, throttle = 1'b0;
  string tag_rx = "R10", tag_tx = "R10";

  // reference model state
  bit          m_cfg = 0, m_wide = 0, m_uni = 0;
  bit          have_lo = 0;
  int          held_lo = 0;
  bit          e_rv = 0, e_hb = 0;
  int          e_word = 0;
  int          txq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_wide = 0; m_uni = 0; have_lo = 0;
      e_rv = 0; e_hb = 0; txq.delete();
    end else begin
      bit rdy_now, wide_now, uni_now;
      wide_now = m_cfg && m_wide;
      uni_now  = m_cfg && m_uni && !m_wide;
      // receive
      e_rv = 0; e_hb = 0;
      if (s_rx_vld) begin
        if (!wide_now) begin e_word = s_rx_byte; e_rv = 1; end
        else if (have_lo) begin
          e_word = (int'(s_rx_byte) << 8) | held_lo; e_rv = 1; e_hb = 1; have_lo = 0;
        end else begin held_lo = s_rx_byte; have_lo = 1; end
      end else if (s_rx_end && have_lo) begin
        e_word = held_lo; e_rv = 1; have_lo = 0;
      end
      // transmit
      rdy_now = (txq.size() == 0) || (txq.size() == 1 && s_tx_rdy);
      if (txq.size() > 0 && s_tx_rdy) void'(txq.pop_front());
      if (tx_valid && rdy_now) begin
        if (wide_now) begin
          txq.push_back(bus_tx[7:0]);
          if (hbv_in) txq.push_back(bus_tx[15:8]);
        end else if (uni_now) txq.push_back(bus_tx[15:8]);
        else txq.push_back(bus_tx[7:0]);
      end
      if (!m_cfg) begin m_cfg = 1; m_wide = wide_sel; m_uni = uni_sel; end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit exp_ready;
    chk(tag_rx, "rx_valid", rx_valid, e_rv);
    if (e_rv) chk(tag_rx, "bus_rx", bus_rx, e_word);
    chk(tag_rx, "hbv_o", hbv_out, e_hb);
    chk("R5", "hbv_oe", hbv_oe, (m_cfg && m_wide && !tx_valid) ? 1 : 0);
    exp_ready = (txq.size() == 0) || (txq.size() == 1 && s_tx_rdy);
    chk(tag_tx, "tx_ready", tx_ready, exp_ready);
    chk("R9", "ser_tx_vld", s_tx_vld, txq.size() > 0);
    if (txq.size() > 0) chk(tag_tx, "ser_tx_byte", s_tx_byte, txq[0]);
  endtask

  // advance one clock, compare away from the edge, update serializer ready
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compare();
    s_tx_rdy = throttle ? ((cyc % 3) != 0) : 1'b1;
  endtask

  task automatic do_reset(bit w, bit u);
    rst_n = 1'b0; wide_sel = w; uni_sel = u;
    tx_valid = 0; s_rx_vld = 0; s_rx_end = 0;
    tag_rx = "R10"; tag_tx = "R10";
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    tick();
  endtask

  task automatic rx_packet(int n, int seed);
    for (int i = 0; i < n; i++) begin
      s_rx_byte = BW'(seed + 17 * i); s_rx_vld = 1; tick();
    end
    s_rx_vld = 0; s_rx_end = 1; tick();
    s_rx_end = 0; tick(); tick();
  endtask

  task automatic tx_word(logic [WW-1:0] w, bit h);
    bus_tx = w; hbv_in = h; tx_valid = 1;
    for (int k = 0; k < 50; k++) begin
      bit acc;
      #0.5;
      acc = tx_ready;
      tick();
      if (acc) break;
    end
  endtask

  task automatic tx_end();
    tx_valid = 0; hbv_in = 0;
    for (int k = 0; k < 20 && s_tx_vld; k++) tick();
    tick();
  endtask

  initial begin
    // bidirectional narrow
    do_reset(0, 0);
    tag_rx = "R2"; rx_packet(5, 8'h31);
    tag_tx = "R6";
    tx_word(16'hAA11, 0); tx_word(16'hBB22, 1); tx_word(16'hCC33, 0); tx_end();
    throttle = 1; tag_tx = "R9";
    tx_word(16'h0144, 0); tx_word(16'h0255, 0); tx_word(16'h0366, 0); tx_end();
    throttle = 0;
    // wide; selects flipped right after latch
    do_reset(1, 0);
    wide_sel = 0; uni_sel = 1;
    tag_rx = "R1"; rx_packet(2, 8'h90);
    tag_rx = "R3"; rx_packet(4, 8'h05);
    tag_rx = "R4"; rx_packet(3, 8'h60); rx_packet(1, 8'hE1); rx_packet(0, 0);
    tag_tx = "R7";
    tx_word(16'h2211, 1); tx_word(16'h4433, 1); tx_word(16'h6655, 0); tx_end();
    throttle = 1; tag_tx = "R9";
    tx_word(16'h8877, 1); tx_word(16'hAA99, 1); tx_word(16'h00BB, 0); tx_end();
    throttle = 0;
    // unidirectional narrow
    do_reset(0, 1);
    tag_rx = "R8"; rx_packet(4, 8'h7C);
    tag_tx = "R8";
    tx_word(16'hD10F, 1); tx_word(16'hE20E, 0); tx_word(16'hF30D, 0); tx_end();
    // reset values again, with traffic in flight
    tx_valid = 1; bus_tx = 16'h1234; tick();
    rst_n = 0; tx_valid = 0; tag_rx = "R10"; tag_tx = "R10";
    #1;
    chk("R10", "rx_valid", rx_valid, 0);
    chk("R10", "hbv_oe", hbv_oe, 0);
    chk("R10", "ser_tx_vld", s_tx_vld, 0);
    chk("R10", "tx_ready", tx_ready, 1);
    tick(); tick();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule